// File: doc/BRIEF.md
# Byte-Programmed Eight-Line Priority Interrupt Controller

This block collects requests from eight interrupt lines and raises a single interrupt output towards a processor. When the processor acknowledges, the block returns an 8-bit vector that identifies the winning line. It keeps three 8-bit registers: pending requests, lines in service, and blocked lines. Priority is fixed. Line 0 is the most urgent and line 7 the least urgent. A request reaches the processor only if it outranks everything that is already in service.

Software controls the block through a small byte-addressed register window with four addresses:

| Address | Access | Purpose |
|---|---|---|
| 0 | read/write | command |
| 1 | read/write | data |
| 2 | read/write | trigger mode |
| 3 | read only | cascade word |

A command write with bit 4 set starts a programming sequence. The data writes that follow are then taken as setup words:

1. The vector base.
2. A cascade word, which is only stored.
3. An optional mode word.

Outside that sequence, the data address reads and writes the block mask. Other command writes do the following:
- Select whether command reads return the in-service or the pending register.
- Retire the most urgent in-service line.

The trigger-mode register chooses edge or level sensing for each line. If a request disappears before the acknowledge, the block answers with the vector of line 7 and leaves the in-service register unchanged, so software can recognise a false interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset:
  - The mask reads 0xFF.
  - The pending and in-service registers are 0.
  - Command reads return the pending register.
  - The trigger-mode register is 0x00, so every line is edge-sensed.
  - `irq_out` is low.
- R2: A command write with bit 4 set has these effects:
  - It restarts setup and clears the in-service register.
  - It points command reads at the pending register.
  - It leaves the mask unchanged.
  - The following data writes are taken as setup words and are not written to the mask.
- R3: The first setup word is the vector base B. The mode word (bit 0 = 1) selects a vector of `{B[7:3], n}` for line n. Otherwise the vector is B+n. If bit 0 of the starting command is 0, no mode word is expected and the mode bit is 0.
- R4: The second setup word is stored and read back at address 3. It has no other effect.
- R5: Outside setup, data writes and reads access the mask. A 1 in bit n blocks line n from raising `irq_out`, but its pending bit is still recorded.
- R6: Command writes select what command reads return:
  - 0x0B selects the in-service register.
  - 0x0A selects the pending register.
- R7: Line 0 has the highest priority. `irq_out` is high only when some unblocked pending line outranks every in-service line.
- R8: During a one-cycle `inta` pulse, `vector` carries the winner's code. At the following clock edge the winner's in-service bit is set and, for an edge-sensed line, its pending bit is cleared.
- R9: A command write of 0x20 clears the lowest-numbered set in-service bit.
- R10: If no request is eligible at `inta`, the vector is the one for line 7 and in-service bit 7 is not set.
- R11: Trigger-mode bit n set to 1 makes line n level-sensed: its pending bit follows the input. Bit n set to 0 makes it edge-sensed: the pending bit is set by a rising edge, held while the input stays high, and dropped when the input goes low. The register is readable and writable at address 2.
- R12: `irq_out` stays low while a setup sequence is incomplete.
- R13: Command writes that match none of the encodings above change nothing. Examples are 0x0C, with bit 3 set and low bits 00, and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 command, 1 data, 2 trigger mode, 3 cascade word |
| wr | input | 1 | Write strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_in | input | 8 | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | Acknowledge pulse for one cycle |
| vector | output | 8 | Vector, valid while `inta` is high, otherwise 0 |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:
- **Request withdrawn before acknowledge.** A design that trusts the stale interrupt would return the real line's vector or mark bit 7 in service.
- **Lower-priority line while a higher one is in service.** Wrong nesting logic would interrupt anyway.
- **Retire command with two nested lines in service.** Retiring the wrong bit would release the waiting request too early.
- **Level-sensed line after retirement.** It must interrupt again, while an edge-sensed line held high must not. A design that mixes up the trigger modes would show either a lost or a repeated interrupt.
- **Request arriving during a setup sequence.** An interrupt raised mid-sequence, or setup words written into the mask, would show up directly at the ports.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       irq_out,
  input  logic       inta,
  output logic [7:0] vector
);
  localparam int IW = $clog2(N);

  typedef enum logic [1:0] {S_IDLE, S_BASE, S_CASC, S_MODE} seq_t;

  logic [N-1:0] pend, insvc, blk, lvl, in_q;
  logic [7:0]   base, casc;
  logic         mode86, want_mode, show_isr;
  seq_t         seq;

  function automatic logic [IW:0] first_set(input logic [N-1:0] v);
    first_set = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) first_set = {1'b1, IW'(i)};
  endfunction

  wire cmd_wr   = wr && addr == 2'd0;
  wire dat_wr   = wr && addr == 2'd1;
  wire trg_wr   = wr && addr == 2'd2;
  wire init_go  = cmd_wr && wdata[4];
  wire sel_cmd  = cmd_wr && !wdata[4] && wdata[3] && wdata[1];
  wire eoi      = cmd_wr && wdata == 8'h20;

  wire [IW:0]  top_isr = first_set(insvc);
  wire [N-1:0] above   = top_isr[IW] ? (N'(1) << top_isr[IW-1:0]) - N'(1) : '1;
  wire [N-1:0] elig    = pend & ~blk & above;
  wire [IW:0]  win     = first_set(elig);

  assign irq_out = seq == S_IDLE && |elig;
  wire   ack_hit = inta && irq_out;

  wire [IW-1:0] vsel = ack_hit ? win[IW-1:0] : IW'(N - 1);
  assign vector = !inta ? 8'h00
                : mode86 ? {base[7:IW], vsel}
                : base + 8'(vsel);

  always_comb begin
    case (addr)
      2'd0:    rdata = show_isr ? insvc : pend;
      2'd1:    rdata = blk;
      2'd2:    rdata = lvl;
      default: rdata = casc;
    endcase
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    wire rise = irq_in[g] && !in_q[g];
    wire take = ack_hit && win[IW-1:0] == IW'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend[g] <= 1'b0;
      else if (lvl[g])
        pend[g] <= irq_in[g];
      else
        pend[g] <= irq_in[g] && (pend[g] || rise) && !take;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= irq_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      insvc <= '0;
    end else if (init_go) begin
      insvc <= '0;
    end else begin
      logic [N-1:0] nx;
      nx = insvc;
      if (eoi && top_isr[IW]) nx[top_isr[IW-1:0]] = 1'b0;
      if (ack_hit)            nx[win[IW-1:0]]     = 1'b1;
      insvc <= nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq       <= S_IDLE;
      blk       <= '1;
      lvl       <= '0;
      base      <= 8'h00;
      casc      <= 8'h00;
      mode86    <= 1'b0;
      want_mode <= 1'b0;
      show_isr  <= 1'b0;
    end else begin
      if (trg_wr) lvl <= wdata;
      if (init_go) begin
        seq       <= S_BASE;
        want_mode <= wdata[0];
        mode86    <= 1'b0;
        show_isr  <= 1'b0;
      end else if (sel_cmd) begin
        show_isr  <= wdata[0];
      end
      if (dat_wr) begin
        case (seq)
          S_BASE: begin base <= wdata; seq <= S_CASC; end
          S_CASC: begin casc <= wdata; seq <= want_mode ? S_MODE : S_IDLE; end
          S_MODE: begin mode86 <= wdata[0]; seq <= S_IDLE; end
          default: blk <= wdata;
        endcase
      end
    end
  end

  // R8
  one_new_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(insvc & ~$past(insvc)) <= 1);

  // R12
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> !irq_out);

  // R10
  spur_keep7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !irq_out && !cmd_wr) |=> insvc[N-1] == $past(insvc[N-1]));

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(pend & ~blk));

  // R9
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !inta && |insvc) |=> $countones(insvc) + 1 == $countones($past(insvc)));

  // R2
  init_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> insvc == '0);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       irq_out;
  logic       inta = 1'b0;
  logic [7:0] vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string      req;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out), .inta(inta),
    .vector(vector)
  );

  initial begin : monitor
    forever begin
      item_t it;
      logic [7:0] act;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = vector;
        default: act = {7'd0, irq_out};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(string req, int kind, logic [7:0] exp);
    exp_q.push_back('{req, kind, exp});
    #1;
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic chk_rd(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1;
    push(req, 0, exp);
  endtask

  task automatic chk_irq(logic v, string req);
    @(negedge clk);
    #1;
    push(req, 2, {7'd0, v});
  endtask

  task automatic ack(logic [7:0] exp, string req);
    @(negedge clk);
    inta = 1'b1;
    #1;
    push(req, 1, exp);
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic set_in(logic [7:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk_rd(0, 8'h00, "R1 pending");
    chk_rd(1, 8'hFF, "R1 mask");
    chk_rd(2, 8'h00, "R1 trigger");
    chk_irq(1'b0, "R1 irq");

    wreg(0, 8'h11); wreg(1, 8'h20); wreg(1, 8'h04); wreg(1, 8'h01);
    chk_rd(3, 8'h04, "R4 cascade");
    chk_rd(1, 8'hFF, "R2 mask kept");
    wreg(1, 8'h00);
    chk_rd(1, 8'h00, "R5 mask write");

    set_in(8'h08);
    chk_irq(1'b1, "R7 single");
    chk_rd(0, 8'h08, "R6 pending view");
    ack(8'h23, "R8 vector line3");
    chk_irq(1'b0, "R8 after ack");
    wreg(0, 8'h0B);
    chk_rd(0, 8'h08, "R6 isr view");
    wreg(0, 8'h0A);
    chk_rd(0, 8'h00, "R11 edge no relatch");

    set_in(8'h28);
    chk_irq(1'b0, "R7 lower blocked");
    set_in(8'h2A);
    chk_irq(1'b1, "R7 higher nests");
    ack(8'h21, "R8 vector line1");
    wreg(0, 8'h0B);
    chk_rd(0, 8'h0A, "R8 isr nested");
    wreg(0, 8'h20);
    chk_rd(0, 8'h08, "R9 first eoi");
    chk_irq(1'b0, "R9 still blocked");
    wreg(0, 8'h20);
    chk_rd(0, 8'h00, "R9 second eoi");
    chk_irq(1'b1, "R9 release");
    ack(8'h25, "R8 vector line5");
    wreg(0, 8'h20);
    set_in(8'h00);

    wreg(1, 8'h01);
    set_in(8'h01);
    chk_irq(1'b0, "R5 masked");
    wreg(0, 8'h0A);
    chk_rd(0, 8'h01, "R5 pending kept");
    wreg(1, 8'h00);
    chk_irq(1'b1, "R5 unmasked");
    ack(8'h20, "R8 vector line0");
    wreg(0, 8'h20);
    set_in(8'h00);

    set_in(8'h40);
    chk_irq(1'b1, "R10 raised");
    set_in(8'h00);
    chk_irq(1'b0, "R10 withdrawn");
    ack(8'h27, "R10 spurious vector");
    wreg(0, 8'h0B);
    chk_rd(0, 8'h00, "R10 bit7 clear");

    wreg(2, 8'h10);
    chk_rd(2, 8'h10, "R11 trigger rw");
    set_in(8'h10);
    chk_irq(1'b1, "R11 level raise");
    ack(8'h24, "R11 vector line4");
    chk_irq(1'b0, "R11 in service");
    wreg(0, 8'h20);
    chk_irq(1'b1, "R11 level again");
    set_in(8'h00);
    chk_irq(1'b0, "R11 level drop");

    set_in(8'h04);
    ack(8'h22, "R8 vector line2");
    chk_rd(0, 8'h04, "R6 isr line2");
    wreg(0, 8'h0C);
    chk_rd(0, 8'h04, "R13 0x0C ignored");
    wreg(0, 8'h00);
    chk_rd(0, 8'h04, "R13 0x00 ignored");

    wreg(0, 8'h10);
    set_in(8'h44);
    chk_irq(1'b0, "R12 during setup");
    wreg(1, 8'h41);
    chk_irq(1'b0, "R12 still setup");
    wreg(1, 8'h00);
    chk_irq(1'b1, "R12 after setup");
    chk_rd(0, 8'h40, "R2 readback reset");
    chk_rd(1, 8'h00, "R2 mask unchanged");
    chk_rd(3, 8'h00, "R4 new cascade");
    wreg(0, 8'h0B);
    chk_rd(0, 8'h00, "R2 isr cleared");
    ack(8'h47, "R3 additive vector");

    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule